// File: doc/BRIEF.md
# Parallel Port Handshake Register Block

This block sits on the host side of a PC-style parallel port. It presents two byte-wide registers on a small register bus. The status register is read-only and is built from the handshake lines that come back from the peripheral. The control register can be read and written, and it drives the outgoing handshake lines. Some of those lines are inverted on the way out and some are not.

The control register also holds the direction of the 8-bit data bus and an enable for an acknowledge interrupt. A 3-bit mode input decides whether the direction bit is used. In mode 000 the direction bit is forced to output and cleared in storage. In mode 010 the direction output stays at output, but the stored bit keeps its written value.

The incoming pins are passed through a synchronizer of `SYNC_STAGES` flip-flops before they are used. A rising edge of the synchronized acknowledge line gives a one-clock interrupt pulse while the enable bit is set. Data FIFOs, DMA and protocol sequencers live elsewhere.

Top module: `pport_regs`

## Requirements
- R1: A read at offset 1 returns {~busy, ack_n, paper_err, select, fault_n, 1, 1, 1}, from bit 7 down to bit 0. Each pin level appears there `SYNC_STAGES` clock edges after it settles.
- R2: A read at offset 2 returns 1 in bits 7 and 6 whatever was written there. Bits 5 to 0 return the stored control value.
- R3: After reset, offset 2 reads 0xC0. The pins are then strobe_n=1, autofd_n=1, init_n=0, selin_n=1, bus_in=0 and irq=0.
- R4: From the clock edge that takes a write: strobe_n_o is the inverse of bit 0, autofd_n_o is the inverse of bit 1, init_n_o equals bit 2, and selin_n_o is the inverse of bit 3.
- R5: In modes other than 000 and 010, bus_in_o equals stored bit 5 (1 = bus is input, 0 = bus is output).
- R6: In mode 010, bus_in_o is 0. Stored bit 5 still reads back as written.
- R7: In mode 000, bit 5 is stored as 0 on any write. The clock edge after the mode becomes 000 also clears a stored 1.
- R8: When control bit 4 is 1, a low-to-high change of ack_n raises irq_o for exactly one clock. The pulse comes `SYNC_STAGES`+1 edges after the change.
- R9: No interrupt pulse occurs on a falling ack_n, or on a rising ack_n while bit 4 is 0.
- R10: rd_data is 0 when rd_en is low or the offset is neither 1 nor 2. A write to any offset other than 2 leaves the control register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Register offset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data (combinational) |
| mode | input | 3 | Port operating mode |
| busy_i | input | 1 | Peripheral busy line |
| ack_n_i | input | 1 | Peripheral acknowledge, active low |
| paper_err_i | input | 1 | Peripheral paper error line |
| select_i | input | 1 | Peripheral selected line |
| fault_n_i | input | 1 | Peripheral fault, active low |
| strobe_n_o | output | 1 | Data strobe to peripheral, active low |
| autofd_n_o | output | 1 | Auto line feed, active low |
| init_n_o | output | 1 | Initialize peripheral, active low |
| selin_n_o | output | 1 | Select peripheral, active low |
| bus_in_o | output | 1 | Data bus direction, 1 = input |
| irq_o | output | 1 | Acknowledge interrupt pulse |

## Verification
The bench uses the defaults `ADDR_W`=3 and `SYNC_STAGES`=2. The 3-bit offset lets every one of the eight offsets be read and written, so R10 is checked on the whole address space. With only two synchronizer stages, the latency of the status and interrupt paths is a short, exact cycle count that the bench can check. At this size all 32 status pin patterns are swept, and all 256 control bytes are written in each of the eight modes.

// File: rtl/pport_pkg.sv
package pport_pkg;

    typedef logic [2:0] pmode_t;

    localparam pmode_t MODE_COMPAT   = 3'b000;
    localparam pmode_t MODE_FIFO_FWD = 3'b010;

    // Stored control bits, bit 5 down to bit 0
    typedef struct packed {
        logic bus_in;
        logic irq_en;
        logic selin;
        logic init;
        logic autofd;
        logic strobe;
    } ctrl_t;

    localparam int CTRL_W   = $bits(ctrl_t);
    localparam int STAT_PINS = 5;

endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/pport_ctrl.sv
module pport_ctrl
    import pport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [CTRL_W-1:0] wr_bits,
    input  pmode_t            mode,
    output ctrl_t             ctrl_o,
    output logic              bus_in_o
);
    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_hit) ctrl_d = ctrl_t'(wr_bits);
        // compatibility mode pins the direction bit to output
        if (mode == MODE_COMPAT) ctrl_d.bus_in = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign ctrl_o   = ctrl_q;
    assign bus_in_o = (mode == MODE_COMPAT || mode == MODE_FIFO_FWD) ? 1'b0 : ctrl_q.bus_in;
endmodule

// File: rtl/pport_irq.sv
module pport_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_s,
    input  logic irq_en,
    output logic irq_o
);
    typedef struct packed {
        logic ack_prev;
        logic irq;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d.ack_prev = ack_s;
        st_d.irq      = irq_en & ack_s & ~st_q.ack_prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.irq;
endmodule

// File: rtl/pport_regs.sv
module pport_regs
    import pport_pkg::*;
#(
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2,
    parameter int STATUS_OFS  = 1,
    parameter int CTRL_OFS    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    input  logic [2:0]        mode,
    input  logic              busy_i,
    input  logic              ack_n_i,
    input  logic              paper_err_i,
    input  logic              select_i,
    input  logic              fault_n_i,
    output logic              strobe_n_o,
    output logic              autofd_n_o,
    output logic              init_n_o,
    output logic              selin_n_o,
    output logic              bus_in_o,
    output logic              irq_o
);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STATUS_OFS);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);

    logic [STAT_PINS-1:0] pins_raw, pins_s;
    ctrl_t                ctrl;
    logic                 unused_hi;

    assign unused_hi = ^wr_data[7:6];
    assign pins_raw  = {busy_i, ack_n_i, paper_err_i, select_i, fault_n_i};

    generate
        if (SYNC_STAGES > 0) begin : g_sync
            pport_sync #(.W(STAT_PINS), .STAGES(SYNC_STAGES)) u_sync (
                .clk  (clk),
                .rst_n(rst_n),
                .din  (pins_raw),
                .dout (pins_s)
            );
        end else begin : g_nosync
            assign pins_s = pins_raw;
        end
    endgenerate

    pport_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hit  (wr_en && addr == CTRL_A),
        .wr_bits (wr_data[CTRL_W-1:0]),
        .mode    (pmode_t'(mode)),
        .ctrl_o  (ctrl),
        .bus_in_o(bus_in_o)
    );

    pport_irq u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .ack_s (pins_s[3]),
        .irq_en(ctrl.irq_en),
        .irq_o (irq_o)
    );

    assign strobe_n_o = ~ctrl.strobe;
    assign autofd_n_o = ~ctrl.autofd;
    assign init_n_o   =  ctrl.init;
    assign selin_n_o  = ~ctrl.selin;

    always_comb begin
        rd_data = 8'h00;
        if (rd_en) begin
            if (addr == STAT_A)      rd_data = {~pins_s[4], pins_s[3:0], 3'b111};
            else if (addr == CTRL_A) rd_data = {2'b11, ctrl};
        end
    end
endmodule

// File: rtl/pport_regs_chk.sv
module pport_regs_chk #(
    parameter int ADDR_W     = 3,
    parameter int STATUS_OFS = 1,
    parameter int CTRL_OFS   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              rd_en,
    input logic              wr_en,
    input logic [7:0]        wr_data,
    input logic [7:0]        rd_data,
    input logic [2:0]        mode,
    input logic              strobe_n_o,
    input logic              autofd_n_o,
    input logic              init_n_o,
    input logic              selin_n_o,
    input logic              bus_in_o,
    input logic              irq_o
);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STATUS_OFS);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);

    assert_status_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == STAT_A) |-> rd_data[2:0] == 3'b111);

    assert_ctrl_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == CTRL_A) |-> rd_data[7:6] == 2'b11);

    assert_pin_map_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == CTRL_A) |=> (strobe_n_o == !$past(wr_data[0]) &&
                                       autofd_n_o == !$past(wr_data[1]) &&
                                       init_n_o   ==  $past(wr_data[2]) &&
                                       selin_n_o  == !$past(wr_data[3])));

    assert_fwd_dir_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'b010) |-> !bus_in_o);

    assert_compat_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'b000) |=> !(mode == 3'b000 && rd_en && addr == CTRL_A && rd_data[5]));

    assert_irq_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    assert_other_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en || (addr != STAT_A && addr != CTRL_A)) |-> rd_data == 8'h00);
endmodule

bind pport_regs pport_regs_chk #(
    .ADDR_W    (ADDR_W),
    .STATUS_OFS(STATUS_OFS),
    .CTRL_OFS  (CTRL_OFS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .mode      (mode),
    .strobe_n_o(strobe_n_o),
    .autofd_n_o(autofd_n_o),
    .init_n_o  (init_n_o),
    .selin_n_o (selin_n_o),
    .bus_in_o  (bus_in_o),
    .irq_o     (irq_o)
);

// File: tb/pport_regs_test.sv
module pport_regs_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          rd_en = 1'b0, wr_en = 1'b0;
    logic [7:0]    wr_data = '0;
    logic [7:0]    rd_data;
    logic [2:0]    mode = 3'b001;
    logic          busy_i = 1'b0, ack_n_i = 1'b1, paper_err_i = 1'b0, select_i = 1'b0, fault_n_i = 1'b1;
    logic          strobe_n_o, autofd_n_o, init_n_o, selin_n_o, bus_in_o, irq_o;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pport_regs #(.ADDR_W(AW), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .mode(mode),
        .busy_i(busy_i), .ack_n_i(ack_n_i), .paper_err_i(paper_err_i),
        .select_i(select_i), .fault_n_i(fault_n_i),
        .strobe_n_o(strobe_n_o), .autofd_n_o(autofd_n_o), .init_n_o(init_n_o),
        .selin_n_o(selin_n_o), .bus_in_o(bus_in_o), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // called just after a negedge; value sampled in the low half
    task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
        addr = a; rd_en = 1'b1;
        #1 v = rd_data;
        rd_en = 1'b0;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] v);
        addr = a; wr_data = v; wr_en = 1'b1;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [7:0] pins();
        return {3'b000, bus_in_o, selin_n_o, init_n_o, autofd_n_o, strobe_n_o};
    endfunction

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
    end

    initial begin
        logic [7:0] v;
        logic [7:0] exp_c;
        logic       exp_dir;

        cycles(2);
        rst_n = 1'b1;
        cycles(3);

        // R3 reset state
        rd(AW'(2), v);
        check("R3 ctrl reset", v, 8'hC0);
        check("R3 pins reset", pins(), 8'b0000_1011);
        check("R3 irq reset", {7'b0, irq_o}, 8'h00);

        // R1 status sweep over all pin patterns
        for (int p = 0; p < 32; p++) begin
            busy_i = p[4]; ack_n_i = p[3]; paper_err_i = p[2]; select_i = p[1]; fault_n_i = p[0];
            cycles(2);
            rd(AW'(1), v);
            check("R1 status", v, {~p[4], p[3], p[2], p[1], p[0], 3'b111});
        end
        ack_n_i = 1'b1;
        cycles(3);

        // R2 R4 R5 R6 R7 all bytes in all modes
        for (int m = 0; m < 8; m++) begin
            mode = m[2:0];
            cycles(1);
            for (int b = 0; b < 256; b++) begin
                wr(AW'(2), 8'(b));
                exp_c   = {2'b11, (m == 0) ? 1'b0 : b[5], b[4:0]};
                exp_dir = (m == 0 || m == 2) ? 1'b0 : b[5];
                rd(AW'(2), v);
                check("R2 R7 ctrl readback", v, exp_c);
                check("R4 R5 R6 pins", pins(), {3'b000, exp_dir, ~b[3], b[2], ~b[1], ~b[0]});
            end
        end

        // R7 entering mode 000 clears a stored direction bit
        mode = 3'b011;
        cycles(1);
        wr(AW'(2), 8'h20);
        rd(AW'(2), v);
        check("R5 dir set", v, 8'hE0);
        check("R5 bus_in", {7'b0, bus_in_o}, 8'h01);
        mode = 3'b000;
        cycles(1);
        mode = 3'b011;
        #1;
        rd(AW'(2), v);
        check("R7 cleared on mode 000", v, 8'hC0);
        check("R7 bus_in after clear", {7'b0, bus_in_o}, 8'h00);

        // R10 other offsets: reads zero, writes ignored
        wr(AW'(2), 8'h15);
        for (int a = 0; a < 8; a++) begin
            if (a != 1 && a != 2) begin
                wr(AW'(a), 8'hFF);
                rd(AW'(a), v);
                check("R10 other read", v, 8'h00);
                rd(AW'(2), v);
                check("R10 ctrl kept", v, 8'hD5);
            end
        end
        addr = AW'(2); #1;
        check("R10 no rd_en", rd_data, 8'h00);

        // R8 rising ack with enable
        wr(AW'(2), 8'h10);
        ack_n_i = 1'b0;
        cycles(4);
        ack_n_i = 1'b1;
        cycles(2);
        check("R8 irq not yet", {7'b0, irq_o}, 8'h00);
        cycles(1);
        check("R8 irq pulse", {7'b0, irq_o}, 8'h01);
        cycles(1);
        check("R8 irq one cycle", {7'b0, irq_o}, 8'h00);

        // R9 falling edge: no pulse
        ack_n_i = 1'b0;
        for (int i = 0; i < 5; i++) begin
            cycles(1);
            check("R9 no irq on fall", {7'b0, irq_o}, 8'h00);
        end

        // R9 rising edge with enable clear
        wr(AW'(2), 8'h00);
        ack_n_i = 1'b1;
        for (int i = 0; i < 5; i++) begin
            cycles(1);
            check("R9 no irq disabled", {7'b0, irq_o}, 8'h00);
        end

        summary();
    end
endmodule